// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block sits beside one private cache in a shared-bus multiprocessor and keeps that cache's copy of each line coherent with the other caches. Each line of a small direct-mapped line array carries one of three coherence states: Modified (this cache holds the only current copy), Shared (a clean copy that others may also hold) or Invalid. The controller serves local processor reads and writes, asks the bus for the transactions it needs (shared read, exclusive read, write-back of a dirty victim) and watches the bus for transactions issued by other caches. When another cache asks for a line that is held here as Modified, the controller puts the line on the bus (a flush) the same cycle.

Addresses are split, from least to most significant, into a word offset, a line index and a tag. The bus, snoop and write-back addresses are line addresses `{tag, index}`. Bus operation codes on `bus_op` and `snp_op` are 1 = shared read, 2 = exclusive read, 3 = write-back. A fill arrives on `bus_rdata` in the cycle the grant is given. The processor holds its request stable until `cpu_ack`.

The request state machine has five states: IDLE (accept a request), EVICT (waiting to write back a Modified victim), FILL (waiting to issue a shared or exclusive read for a miss), UPGR (waiting to issue an exclusive read that turns a Shared line into Modified) and RESP (one-cycle acknowledge). Transitions: IDLE to RESP on a local hit that needs no bus; IDLE to UPGR on a write to a Shared line; IDLE to EVICT on a miss whose victim is Modified; IDLE to FILL on any other miss; EVICT to FILL on the write-back grant or when a snoop takes the victim out of Modified; UPGR to FILL when a snoop invalidates the target line; FILL and UPGR to RESP on grant; RESP to IDLE. A request whose line is hit by a snoop in the same cycle waits one cycle in IDLE.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ack`, `bus_req` and `flush` are 0, and no snoop produces a flush until a line has been written.
- R2: A read of a Modified or Shared line, or a write of a Modified line, raises `cpu_ack` with no bus request; a read returns the addressed word, a write returns the written word.
- R3: A write to a Shared line requests an exclusive read (code 2) at the line address, and the line then becomes Modified with the written word merged in.
- R4: A read that misses requests a shared read (code 1) and installs the bus line as Shared; the addressed word of the fill is returned.
- R5: A write that misses requests an exclusive read (code 2) and installs the fill with the written word merged in as Modified.
- R6: A snooped shared read of a Modified line raises `flush` in the same cycle with the line on `flush_data`, and the line becomes Shared.
- R7: A snooped exclusive read of a Modified line flushes and invalidates it; of a Shared line it invalidates without a flush.
- R8: A snooped shared read of a Shared line, a snoop whose tag does not match, and any snoop of an Invalid line cause no flush and no state change.
- R9: A miss whose victim is Modified first requests a write-back (code 3) with the victim's line address on `bus_addr` and its data on `bus_wdata`, then the fill request.
- R10: While waiting for a grant the request keeps `bus_req`, `bus_op` and `bus_addr` steady, and snoops are served; a snoop that takes the victim out of Modified cancels the write-back and the fill request follows directly.
- R11: If a snoop invalidates the line a pending upgrade targets, the request becomes an exclusive-read miss: the fill data from the bus is used and the written word is merged into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W+OFF_W | Word address {tag, index, offset} |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Addressed word after the access, held until the next access |
| bus_req | output | 1 | Bus request |
| bus_op | output | 2 | Requested operation: 1 shared read, 2 exclusive read, 3 write-back |
| bus_addr | output | TAG_W+IDX_W | Line address of the request |
| bus_wdata | output | WORD_W*WORDS | Victim line for a write-back |
| bus_gnt | input | 1 | Grant; the request is carried out at this edge |
| bus_rdata | input | WORD_W*WORDS | Fill line, valid with the grant |
| snp_valid | input | 1 | A bus operation from another cache is observed |
| snp_op | input | 2 | Observed operation code |
| snp_addr | input | TAG_W+IDX_W | Observed line address |
| flush | output | 1 | This cache supplies the snooped line |
| flush_data | output | WORD_W*WORDS | Line supplied with the flush |

## Verification
A sweep takes a line into each of the three states and then applies a local read, a local write, a snooped shared read, a snooped exclusive read and a snooped exclusive read with a foreign tag, each followed by probes that reveal the resulting state through flushes and bus requests; this separates every state/event arc of the protocol. A long pseudo-random mix of reads, writes and snoops across all addresses, with grant delays of zero to two cycles, exercises dirty evictions and waits against an arithmetic reference of states, tags, line contents and memory. Two directed sequences insert a snoop during a pending request: one invalidates the target of an upgrade, and a differing word in the bus line shows whether the fill was taken; the other flushes the victim of a pending write-back and shows that the write-back is dropped.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_RD   = 2'd1,
        BOP_RDX  = 2'd2,
        BOP_WB   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_EVICT,
        F_FILL,
        F_UPGR,
        F_RESP
    } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 2,
    parameter int LINE_W = 16,
    localparam int NLINE = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [LINE_W-1:0] a_line,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [LINE_W-1:0] b_line,
    input  logic              loc_we,
    input  line_st_e          loc_st,
    input  logic [TAG_W-1:0]  loc_tag,
    input  logic [LINE_W-1:0] loc_line,
    input  logic              snp_we,
    input  line_st_e          snp_st
);
    line_st_e          st_q   [NLINE];
    logic [TAG_W-1:0]  tag_q  [NLINE];
    logic [LINE_W-1:0] line_q [NLINE];

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_line = line_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_line = line_q[b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINE; i++) st_q[i] <= LN_I;
        end else begin
            if (loc_we) st_q[a_idx] <= loc_st;
            if (snp_we) st_q[b_idx] <= snp_st;
        end
    end

    always_ff @(posedge clk) begin
        if (loc_we) begin
            tag_q[a_idx]  <= loc_tag;
            line_q[a_idx] <= loc_line;
        end
    end

    // R7
    snp_upd_chk: assert property (@(posedge clk) disable iff (rst)
        snp_we |=> st_q[$past(b_idx)] == $past(snp_st));
endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
#(
    parameter int TAG_W = 2
) (
    input  logic             snp_valid,
    input  bus_op_e          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             st_we,
    output line_st_e         st_nxt,
    output logic             flush
);
    logic match;
    assign match = snp_valid && (line_st != LN_I) && (line_tag == snp_tag);

    always_comb begin
        st_we  = 1'b0;
        st_nxt = line_st;
        flush  = 1'b0;
        if (match) begin
            unique case (line_st)
                LN_M: begin
                    if (snp_op == BOP_RD) begin
                        flush  = 1'b1;
                        st_we  = 1'b1;
                        st_nxt = LN_S;
                    end else if (snp_op == BOP_RDX) begin
                        flush  = 1'b1;
                        st_we  = 1'b1;
                        st_nxt = LN_I;
                    end
                end
                LN_S: begin
                    if (snp_op == BOP_RDX) begin
                        st_we  = 1'b1;
                        st_nxt = LN_I;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int IDX_W  = 2,
    parameter int WORD_W = 8,
    parameter int WORDS  = 2,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int ADDR_W  = TAG_W + IDX_W + OFF_W,
    localparam int LADDR_W = TAG_W + IDX_W,
    localparam int LINE_W  = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ack,
    output logic [WORD_W-1:0]  cpu_rdata,
    input  line_st_e           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [LINE_W-1:0]  line_data,
    input  logic               snp_busy,
    input  logic               snp_touch,
    output logic               bus_req,
    output bus_op_e            bus_op,
    output logic [LADDR_W-1:0] bus_addr,
    output logic [LINE_W-1:0]  bus_wdata,
    input  logic               bus_gnt,
    input  logic [LINE_W-1:0]  bus_rdata,
    output logic               loc_we,
    output line_st_e           loc_st,
    output logic [TAG_W-1:0]   loc_tag,
    output logic [LINE_W-1:0]  loc_line
);
    ctl_st_e             st_q, st_d;
    logic [WORD_W-1:0]   rdata_q, rdata_d;
    logic [OFF_W-1:0]    off;
    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic                hit;
    logic [LINE_W-1:0]   mrg_loc, mrg_fill;

    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: IDX_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign hit = (line_st != LN_I) && (line_tag == tag);

    always_comb begin
        mrg_loc  = line_data;
        mrg_fill = bus_rdata;
        mrg_loc[int'(off)*WORD_W +: WORD_W]  = cpu_wdata;
        mrg_fill[int'(off)*WORD_W +: WORD_W] = cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= F_IDLE;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    assign cpu_ack   = (st_q == F_RESP);
    assign cpu_rdata = rdata_q;

    always_comb begin
        st_d      = st_q;
        rdata_d   = rdata_q;
        bus_req   = 1'b0;
        bus_op    = BOP_NONE;
        bus_addr  = {tag, idx};
        bus_wdata = line_data;
        loc_we    = 1'b0;
        loc_st    = line_st;
        loc_tag   = tag;
        loc_line  = line_data;
        unique case (st_q)
            F_IDLE: begin
                if (cpu_req && !snp_busy) begin
                    if (hit && (line_st == LN_M || !cpu_we)) begin
                        loc_we   = cpu_we;
                        loc_st   = LN_M;
                        loc_line = mrg_loc;
                        rdata_d  = cpu_we ? cpu_wdata
                                          : line_data[int'(off)*WORD_W +: WORD_W];
                        st_d     = F_RESP;
                    end else if (hit) begin
                        st_d = F_UPGR;
                    end else if (line_st == LN_M) begin
                        st_d = F_EVICT;
                    end else begin
                        st_d = F_FILL;
                    end
                end
            end
            F_EVICT: begin
                bus_req  = 1'b1;
                bus_op   = BOP_WB;
                bus_addr = {line_tag, idx};
                if (snp_touch) begin
                    st_d = F_FILL;
                end else if (bus_gnt && !snp_busy) begin
                    loc_we  = 1'b1;
                    loc_st  = LN_I;
                    loc_tag = line_tag;
                    st_d    = F_FILL;
                end
            end
            F_FILL: begin
                bus_req = 1'b1;
                bus_op  = cpu_we ? BOP_RDX : BOP_RD;
                if (bus_gnt && !snp_busy) begin
                    loc_we   = 1'b1;
                    loc_st   = cpu_we ? LN_M : LN_S;
                    loc_line = cpu_we ? mrg_fill : bus_rdata;
                    rdata_d  = cpu_we ? cpu_wdata
                                      : bus_rdata[int'(off)*WORD_W +: WORD_W];
                    st_d     = F_RESP;
                end
            end
            F_UPGR: begin
                bus_req = 1'b1;
                bus_op  = BOP_RDX;
                if (snp_touch) begin
                    st_d = F_FILL;
                end else if (bus_gnt && !snp_busy) begin
                    loc_we   = 1'b1;
                    loc_st   = LN_M;
                    loc_line = mrg_loc;
                    rdata_d  = cpu_wdata;
                    st_d     = F_RESP;
                end
            end
            F_RESP: st_d = F_IDLE;
            default: st_d = F_IDLE;
        endcase
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !snp_busy) |=>
            (bus_req && $stable(bus_op) && $stable(bus_addr)));

    // R11
    upg_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == F_UPGR && snp_touch) |=>
            (st_q == F_FILL && bus_req && bus_op == BOP_RDX));

    // R9
    wb_src_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == BOP_WB) |-> line_st == LN_M);

    // R5
    fill_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == F_FILL && bus_gnt && !snp_busy) |=> cpu_ack);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int IDX_W  = 2,
    parameter int WORD_W = 8,
    parameter int WORDS  = 2,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int ADDR_W  = TAG_W + IDX_W + OFF_W,
    localparam int LADDR_W = TAG_W + IDX_W,
    localparam int LINE_W  = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ack,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               bus_req,
    output logic [1:0]         bus_op,
    output logic [LADDR_W-1:0] bus_addr,
    output logic [LINE_W-1:0]  bus_wdata,
    input  logic               bus_gnt,
    input  logic [LINE_W-1:0]  bus_rdata,
    input  logic               snp_valid,
    input  logic [1:0]         snp_op,
    input  logic [LADDR_W-1:0] snp_addr,
    output logic               flush,
    output logic [LINE_W-1:0]  flush_data
);
    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    line_st_e          a_st, b_st, loc_st, snp_st;
    logic [TAG_W-1:0]  a_tag, b_tag, loc_tag;
    logic [LINE_W-1:0] a_line, b_line, loc_line;
    logic              loc_we, snp_we, snp_busy, snp_touch;
    bus_op_e           op_int;

    assign cpu_idx   = cpu_addr[OFF_W +: IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[LADDR_W-1 -: TAG_W];
    assign snp_busy  = snp_valid && (snp_idx == cpu_idx);
    assign snp_touch = snp_we && (snp_idx == cpu_idx);
    assign bus_op    = op_int;
    assign flush_data = b_line;

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_line(a_line),
        .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_line(b_line),
        .loc_we(loc_we), .loc_st(loc_st), .loc_tag(loc_tag), .loc_line(loc_line),
        .snp_we(snp_we), .snp_st(snp_st)
    );

    msi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_op)), .snp_tag(snp_tag),
        .line_st(b_st), .line_tag(b_tag),
        .st_we(snp_we), .st_nxt(snp_st), .flush(flush)
    );

    msi_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .line_st(a_st), .line_tag(a_tag), .line_data(a_line),
        .snp_busy(snp_busy), .snp_touch(snp_touch),
        .bus_req(bus_req), .bus_op(op_int), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .loc_we(loc_we), .loc_st(loc_st), .loc_tag(loc_tag), .loc_line(loc_line)
    );
endmodule

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ack;
    logic [7:0]  cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_op = '0;
    logic [3:0]  snp_addr = '0;
    logic        flush;
    logic [15:0] flush_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model: states 0=I 1=S 2=M
    logic [1:0]  r_st  [4];
    logic [1:0]  r_tag [4];
    logic [15:0] r_ln  [4];
    logic [15:0] mem   [16];

    always #5 clk = ~clk;

    msi_snoop_ctrl u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .flush(flush), .flush_data(flush_data)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [4:0] a, input logic [7:0] d, input int dly);
        logic [1:0]  ix, tg;
        logic [3:0]  la;
        logic [1:0]  e_op [2];
        logic [3:0]  e_ad [2];
        logic [15:0] e_wd, newln;
        logic [7:0]  e_rd;
        bit          hit;
        int          n_exp, k, w, cyc;
        string       ts;
        ix = a[2:1]; tg = a[4:3]; la = a[4:1];
        hit = (r_st[ix] != 2'd0) && (r_tag[ix] == tg);
        n_exp = 0; e_wd = '0;
        e_op[0] = 0; e_op[1] = 0; e_ad[0] = 0; e_ad[1] = 0;
        if (hit) begin
            newln = r_ln[ix];
            if (we && r_st[ix] == 2'd1) begin
                e_op[0] = 2'd2; e_ad[0] = la; n_exp = 1; ts = "R3";
            end else ts = "R2";
        end else begin
            if (r_st[ix] == 2'd2) begin
                e_op[0] = 2'd3; e_ad[0] = {r_tag[ix], ix}; e_wd = r_ln[ix]; n_exp = 1;
            end
            e_op[n_exp] = we ? 2'd2 : 2'd1; e_ad[n_exp] = la; n_exp++;
            newln = mem[la];
            ts = we ? "R5" : "R4";
        end
        if (we) newln[int'(a[0])*8 +: 8] = d;
        e_rd = newln[int'(a[0])*8 +: 8];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        k = 0; w = 0; cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (bus_gnt) begin bus_gnt = 1'b0; k++; w = 0; end
            if (cpu_ack || cyc > 40) break;
            if (bus_req) begin
                if (k < n_exp) begin
                    chk(bus_op == e_op[k] && bus_addr == e_ad[k],
                        (e_op[k] == 2'd3) ? "R9" : ((w > 0) ? "R10" : ts),
                        {bus_op, bus_addr}, {e_op[k], e_ad[k]});
                    if (e_op[k] == 2'd3) chk(bus_wdata == e_wd, "R9", bus_wdata, e_wd);
                end else chk(1'b0, ts, {bus_op, bus_addr}, 0);
                if (w >= dly) begin
                    bus_gnt = 1'b1;
                    bus_rdata = mem[bus_addr];
                    if (bus_op == 2'd3) mem[bus_addr] = bus_wdata;
                end
                w++;
            end
        end
        chk(cpu_ack, ts, cpu_ack, 1);
        chk(k == n_exp, ts, k, n_exp);
        chk(cpu_rdata == e_rd, ts, cpu_rdata, e_rd);
        cpu_req = 1'b0;
        r_st[ix]  = we ? 2'd2 : (hit ? r_st[ix] : 2'd1);
        r_tag[ix] = tg;
        r_ln[ix]  = newln;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [3:0] la);
        logic [1:0] ix, tg;
        bit match, expf;
        string ts;
        ix = la[1:0]; tg = la[3:2];
        match = (r_st[ix] != 2'd0) && (r_tag[ix] == tg);
        expf = match && r_st[ix] == 2'd2 && (op == 2'd1 || op == 2'd2);
        if (!match) ts = "R8";
        else if (r_st[ix] == 2'd2) ts = (op == 2'd1) ? "R6" : "R7";
        else ts = (op == 2'd2) ? "R7" : "R8";
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = la;
        #1;
        chk(flush == expf, ts, flush, expf);
        if (expf) begin
            chk(flush_data == r_ln[ix], ts, flush_data, r_ln[ix]);
            mem[la] = r_ln[ix];
        end
        if (match) begin
            if (op == 2'd2) r_st[ix] = 2'd0;
            else if (op == 2'd1 && r_st[ix] == 2'd2) r_st[ix] = 2'd1;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  la;
        logic [31:0] seed;
        for (int i = 0; i < 4; i++) begin r_st[i] = 0; r_tag[i] = 0; r_ln[i] = 0; end
        for (int i = 0; i < 16; i++) mem[i] = {4'(i), 4'hA, 4'(15 - i), 4'h5};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ack == 1'b0, "R1", cpu_ack, 0);
        chk(bus_req == 1'b0, "R1", bus_req, 0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            snp_valid = 1'b1; snp_op = 2'(1 + (i % 2)); snp_addr = 4'(i);
            #1 chk(flush == 1'b0, "R1", flush, 0);
        end
        @(negedge clk);
        snp_valid = 1'b0;

        // state x event sweep
        for (int s = 0; s < 3; s++) begin
            for (int e = 0; e < 5; e++) begin
                la = 4'((s * 5 + e) * 7);
                snoop(2'd2, la);
                if (s == 1) cpu_op(1'b0, {la, 1'b0}, 8'h00, 0);
                if (s == 2) cpu_op(1'b1, {la, 1'b0}, 8'(s * 16 + e), 0);
                case (e)
                    0: cpu_op(1'b0, {la, 1'b1}, 8'h00, 1);
                    1: cpu_op(1'b1, {la, 1'b1}, 8'(8'hE0 + e + s), 1);
                    2: snoop(2'd1, la);
                    3: snoop(2'd2, la);
                    default: snoop(2'd2, la ^ 4'b0100);
                endcase
                snoop(2'd1, la);
                cpu_op(1'b0, {la, 1'b1}, 8'h00, 0);
            end
        end

        // R11: snoop invalidates the target of a pending upgrade
        la = 4'b0110;
        snoop(2'd2, la);
        cpu_op(1'b0, {la, 1'b0}, 8'h00, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = {la, 1'b0}; cpu_wdata = 8'h5A;
        @(negedge clk);
        chk(bus_req && bus_op == 2'd2 && bus_addr == la, "R3", {bus_req, bus_op, bus_addr}, {1'b1, 2'd2, la});
        snp_valid = 1'b1; snp_op = 2'd2; snp_addr = la;
        #1 chk(flush == 1'b0, "R7", flush, 0);
        mem[la] = 16'hC3E1;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(bus_req && bus_op == 2'd2 && bus_addr == la, "R11", {bus_req, bus_op, bus_addr}, {1'b1, 2'd2, la});
        bus_gnt = 1'b1; bus_rdata = mem[la];
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(cpu_ack, "R11", cpu_ack, 1);
        chk(cpu_rdata == 8'h5A, "R11", cpu_rdata, 8'h5A);
        cpu_req = 1'b0;
        r_st[2] = 2'd2; r_tag[2] = la[3:2]; r_ln[2] = 16'hC35A;
        cpu_op(1'b0, {la, 1'b1}, 8'h00, 0);
        chk(cpu_rdata == 8'hC3, "R11", cpu_rdata, 8'hC3);

        // R10: snoop flushes the victim of a pending write-back
        cpu_op(1'b1, 5'b11000, 8'h77, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 5'b01001;
        @(negedge clk);
        chk(bus_req && bus_op == 2'd3 && bus_addr == 4'b1100, "R9", {bus_req, bus_op, bus_addr}, {1'b1, 2'd3, 4'b1100});
        snp_valid = 1'b1; snp_op = 2'd1; snp_addr = 4'b1100;
        #1 chk(flush && flush_data == r_ln[0], "R10", flush_data, r_ln[0]);
        mem[4'b1100] = r_ln[0];
        @(negedge clk);
        snp_valid = 1'b0;
        chk(bus_req && bus_op == 2'd1 && bus_addr == 4'b0100, "R10", {bus_req, bus_op, bus_addr}, {1'b1, 2'd1, 4'b0100});
        bus_gnt = 1'b1; bus_rdata = mem[4];
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(cpu_ack, "R10", cpu_ack, 1);
        chk(cpu_rdata == mem[4][15:8], "R4", cpu_rdata, mem[4][15:8]);
        cpu_req = 1'b0;
        r_st[0] = 2'd1; r_tag[0] = 2'd1; r_ln[0] = mem[4];

        // mixed traffic
        seed = 32'h1F2E3D4C;
        for (int n = 0; n < 300; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            case (seed[17:16])
                2'd0: cpu_op(1'b0, seed[24:20], 8'h00, int'(seed[27:26]) % 3);
                2'd1: cpu_op(1'b1, seed[24:20], seed[31:24], int'(seed[27:26]) % 3);
                2'd2: snoop(2'd1, seed[23:20]);
                default: snoop(2'd2, seed[23:20]);
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule